// File: doc/BRIEF.md
# Per-Master Address Remap Controller

This block holds one write-only remap control word and uses it to route an incoming address to a target for each class of interconnect master. The low region at address zero is an alias. What it reaches depends on the master class. The CPU master sees boot ROM or on-chip RAM there. DMA-type masters (standalone DMA engines, the fabric-to-system bridge master, the debug port) see SDRAM or on-chip RAM there. All remaining masters always see SDRAM there.

Two bridge windows overlap in part: a full bridge window and a lightweight bridge window. Each becomes visible only when its enable bit is set. When both cover an address, the lower control bit wins.

The outputs are combinational from the current address, the master class and the stored control word. A write lands on the clock edge and steers decoding from the next cycle. Any address that no visible region claims, and any access from the unused class code, is flagged as a decode error. Such an access selects no target.

Top module: `remap_ctrl`

## Requirements
- R1: After reset the control word is zero. A CPU low-region access selects boot ROM, a DMA-type low-region access selects SDRAM, and both bridge windows decode as errors.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 0 updates the control word at that clock edge. Decoding in the same cycle still uses the old word. A write to any other offset has no effect.
- R3: Only bits 0, 1, 3 and 4 of `cfg_wdata` are stored. Bit 2 and bits 31..5 are ignored.
- R4: `cfg_rdata` always reads zero.
- R5: For the CPU class (`mst_class` = 0), the low region 0x0000_0000..0x0000_FFFF selects boot ROM when bit 0 is 0 and on-chip RAM when bit 0 is 1. Bit 1 has no effect on this class.
- R6: For the DMA-type class (`mst_class` = 1), the low region selects SDRAM when bit 1 is 0 and on-chip RAM when bit 1 is 1. Bit 0 has no effect on this class.
- R7: For the other class (`mst_class` = 2), the low region always selects SDRAM, whatever bits 0 and 1 hold.
- R8: The full bridge window 0xC000_0000..0xFBFF_FFFF selects the full bridge when bit 3 is 1. When bit 3 is 0 it is a decode error.
- R9: The lightweight window 0xFBE0_0000..0xFC1F_FFFF selects the lightweight bridge when bit 4 is 1. Where it overlaps the full bridge window and bit 3 is 1, the full bridge wins. An address in the window that no enabled bridge claims is a decode error.
- R10: Addresses outside every region, and any access with `mst_class` = 3, set `dec_err` and select no target.
- R11: `tgt_sel` is always one-hot: bit 0 boot ROM, 1 on-chip RAM, 2 SDRAM, 3 full bridge, 4 lightweight bridge, 5 none. `dec_err` equals bit 5. The fixed regions are SDRAM 0x0001_0000..0xBFFF_FFFF, boot ROM 0xFFFD_0000..0xFFFD_FFFF and on-chip RAM 0xFFFF_0000..0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control register byte offset |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Read data, always zero |
| mst_class | input | 2 | Master class: 0 CPU, 1 DMA-type, 2 other, 3 unused |
| req_addr | input | 32 | Address to decode |
| tgt_sel | output | 6 | One-hot target select |
| dec_err | output | 1 | Decode error flag |

## Verification
A control write and an address decode can land in the same cycle. That decode must still follow the old control word, and the new word must take over on the next cycle. The bench provokes this by issuing every one of the sixteen writes together with a low-region or bridge probe. It checks the probe before the edge against the model's old word, then checks a probe after the edge against the new word. The overlap between the two bridge windows is a second collision of functions: it is probed under all four combinations of the two bridge bits.

// File: rtl/remap_pkg.sv
package remap_pkg;
    typedef enum logic [1:0] {
        MC_CPU   = 2'd0,
        MC_DMA   = 2'd1,
        MC_OTHER = 2'd2,
        MC_RSVD  = 2'd3
    } mst_class_e;

    localparam int T_ROM   = 0;
    localparam int T_OCRAM = 1;
    localparam int T_SDRAM = 2;
    localparam int T_BRG   = 3;
    localparam int T_LWBRG = 4;
    localparam int T_NONE  = 5;
    localparam int NUM_TGT = 6;

    localparam int W_LOW   = 0;
    localparam int W_SDRAM = 1;
    localparam int W_BRG   = 2;
    localparam int W_LW    = 3;
    localparam int W_ROM   = 4;
    localparam int W_OCRAM = 5;
    localparam int NUM_WIN = 6;

    localparam int B_CPU_LOW = 0;
    localparam int B_DMA_LOW = 1;
    localparam int B_BRG_EN  = 3;
    localparam int B_LW_EN   = 4;

    typedef struct packed {
        logic lw_en;
        logic brg_en;
        logic dma_low;
        logic cpu_low;
    } remap_ctl_t;
endpackage

// File: rtl/remap_ctl_reg.sv
module remap_ctl_reg
    import remap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 8,
    parameter logic [OFS_W-1:0] CTL_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    output remap_ctl_t        ctl_q
);
    logic hit;
    logic unused_wbits;

    assign hit = wr_en && (wr_ofs == CTL_OFS);
    assign unused_wbits = ^{wr_data[DATA_W-1:B_LW_EN+1], wr_data[2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (hit) begin
            ctl_q.cpu_low <= wr_data[B_CPU_LOW];
            ctl_q.dma_low <= wr_data[B_DMA_LOW];
            ctl_q.brg_en  <= wr_data[B_BRG_EN];
            ctl_q.lw_en   <= wr_data[B_LW_EN];
        end
    end
endmodule

// File: rtl/remap_win_match.sv
module remap_win_match #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter logic [ADDR_W-1:0] LIMIT = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = (addr >= BASE) && (addr <= LIMIT);
endmodule

// File: rtl/remap_decode.sv
module remap_decode
    import remap_pkg::*;
(
    input  logic [1:0]         mclass,
    input  logic [NUM_WIN-1:0] win_hit,
    input  remap_ctl_t         ctl,
    output logic [NUM_TGT-1:0] sel
);
    int unsigned pick;

    always_comb begin
        pick = T_NONE;
        if (mclass == MC_RSVD) begin
            pick = T_NONE;
        end else if (win_hit[W_LOW]) begin
            unique case (mclass)
                MC_CPU:  pick = ctl.cpu_low ? T_OCRAM : T_ROM;
                MC_DMA:  pick = ctl.dma_low ? T_OCRAM : T_SDRAM;
                default: pick = T_SDRAM;
            endcase
        end else if (win_hit[W_BRG] && ctl.brg_en) begin
            pick = T_BRG;
        end else if (win_hit[W_LW] && ctl.lw_en) begin
            pick = T_LWBRG;
        end else if (win_hit[W_BRG] || win_hit[W_LW]) begin
            pick = T_NONE;
        end else if (win_hit[W_ROM]) begin
            pick = T_ROM;
        end else if (win_hit[W_OCRAM]) begin
            pick = T_OCRAM;
        end else if (win_hit[W_SDRAM]) begin
            pick = T_SDRAM;
        end
        sel = '0;
        sel[pick] = 1'b1;
    end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 8,
    parameter logic [ADDR_W-1:0] LOW_BASE   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] LOW_LIM    = 32'h0000_FFFF,
    parameter logic [ADDR_W-1:0] SDRAM_BASE = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] SDRAM_LIM  = 32'hBFFF_FFFF,
    parameter logic [ADDR_W-1:0] BRG_BASE   = 32'hC000_0000,
    parameter logic [ADDR_W-1:0] BRG_LIM    = 32'hFBFF_FFFF,
    parameter logic [ADDR_W-1:0] LW_BASE    = 32'hFBE0_0000,
    parameter logic [ADDR_W-1:0] LW_LIM     = 32'hFC1F_FFFF,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'hFFFD_0000,
    parameter logic [ADDR_W-1:0] ROM_LIM    = 32'hFFFD_FFFF,
    parameter logic [ADDR_W-1:0] OCRAM_BASE = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] OCRAM_LIM  = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [1:0]        mst_class,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NUM_TGT-1:0] tgt_sel,
    output logic              dec_err
);
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
        {OCRAM_BASE, ROM_BASE, LW_BASE, BRG_BASE, SDRAM_BASE, LOW_BASE};
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LIM =
        {OCRAM_LIM, ROM_LIM, LW_LIM, BRG_LIM, SDRAM_LIM, LOW_LIM};

    remap_ctl_t         ctl;
    logic [NUM_WIN-1:0] win_hit;

    remap_ctl_reg #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .CTL_OFS('0)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_ofs (cfg_addr),
        .wr_data(cfg_wdata),
        .ctl_q  (ctl)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        remap_win_match #(
            .ADDR_W(ADDR_W),
            .BASE  (WIN_BASE[w]),
            .LIMIT (WIN_LIM[w])
        ) u_match (
            .addr(req_addr),
            .hit (win_hit[w])
        );
    end

    remap_decode u_dec (
        .mclass (mst_class),
        .win_hit(win_hit),
        .ctl    (ctl),
        .sel    (tgt_sel)
    );

    assign dec_err   = tgt_sel[T_NONE];
    assign cfg_rdata = '0;
endmodule

// File: rtl/remap_ctrl_chk.sv
module remap_ctrl_chk
    import remap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic [OFS_W-1:0]   cfg_addr,
    input logic [DATA_W-1:0]  cfg_wdata,
    input logic [1:0]         mst_class,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [NUM_TGT-1:0] tgt_sel,
    input logic               dec_err
);
    logic seen_wr, sh_brg;
    logic in_low, in_brg, in_lw, in_any;

    assign in_low = req_addr <= 32'h0000_FFFF;
    assign in_brg = req_addr >= 32'hC000_0000 && req_addr <= 32'hFBFF_FFFF;
    assign in_lw  = req_addr >= 32'hFBE0_0000 && req_addr <= 32'hFC1F_FFFF;
    assign in_any = req_addr <= 32'hFC1F_FFFF ||
                    (req_addr >= 32'hFFFD_0000 && req_addr <= 32'hFFFD_FFFF) ||
                    req_addr >= 32'hFFFF_0000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_wr <= 1'b0;
            sh_brg  <= 1'b0;
        end else if (cfg_wr_en && cfg_addr == '0) begin
            seen_wr <= 1'b1;
            sh_brg  <= cfg_wdata[3];
        end
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_sel) == 1);

    p_hole_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_any || mst_class == 2'd3) |-> dec_err);

    p_reset_rom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_wr && mst_class == 2'd0 && in_low) |-> tgt_sel[T_ROM]);

    p_brg_vis_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[T_BRG] |-> (sh_brg && in_brg));

    p_lw_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[T_LWBRG] |-> (in_lw && !(in_brg && sh_brg)));

    p_cpu_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == '0) |=>
        (!(mst_class == 2'd0 && in_low) || (tgt_sel[T_OCRAM] == $past(cfg_wdata[0]))));
endmodule

bind remap_ctrl remap_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr_en(cfg_wr_en),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .mst_class(mst_class),
    .req_addr (req_addr),
    .tgt_sel  (tgt_sel),
    .dec_err  (dec_err)
);

// File: tb/sim_remap_ctrl.sv
`timescale 1ns/1ps
module sim_remap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  mst_class = '0;
    logic [31:0] req_addr = '0;
    logic [5:0]  tgt_sel;
    logic        dec_err;

    int n_checks = 0;
    int n_fails  = 0;
    int model    = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    remap_ctrl u0 (.*);

    // Behavioural reference: returns target index 0..5
    function automatic int ref_target(int cls, logic [31:0] a, int ctl);
        if (cls == 3) return 5;
        if (a < 32'h0001_0000) begin
            if (cls == 0) return ctl[0] ? 1 : 0;
            if (cls == 1) return ctl[1] ? 1 : 2;
            return 2;
        end
        if (a >= 32'hC000_0000 && a < 32'hFC00_0000 && ctl[3]) return 3;
        if (a >= 32'hFBE0_0000 && a < 32'hFC20_0000 && ctl[4]) return 4;
        if (a >= 32'hC000_0000 && a < 32'hFC20_0000) return 5;
        if (a < 32'hC000_0000) return 2;
        if (a >= 32'hFFFD_0000 && a < 32'hFFFE_0000) return 0;
        if (a >= 32'hFFFF_0000) return 1;
        return 5;
    endfunction

    function automatic string req_of(int cls, logic [31:0] a);
        if (cls == 3) return "R10";
        if (a < 32'h0001_0000) return cls == 0 ? "R5" : (cls == 1 ? "R6" : "R7");
        if (a >= 32'hFBE0_0000 && a < 32'hFC20_0000) return "R9";
        if (a >= 32'hC000_0000 && a < 32'hFC00_0000) return "R8";
        if (a >= 32'hFC20_0000 && a < 32'hFFFD_0000) return "R10";
        return "R11";
    endfunction

    task automatic check(string tag);
        int exp_i;
        logic [5:0] exp_sel;
        exp_i = ref_target(int'(mst_class), req_addr, model);
        exp_sel = 6'(1 << exp_i);
        n_checks++;
        if (tgt_sel !== exp_sel || dec_err !== (exp_i == 5)) begin
            n_fails++;
            $display("FAIL %s cls=%0d addr=%h ctl=%h: sel=%b err=%b expected sel=%b err=%b",
                     tag, mst_class, req_addr, model, tgt_sel, dec_err, exp_sel, exp_i == 5);
        end
        n_checks++;
        if (cfg_rdata !== 32'h0) begin
            n_fails++;
            $display("FAIL R4 rdata=%h expected 00000000", cfg_rdata);
        end
    endtask

    // One cycle: drive at negedge, compare mid-cycle, update model at posedge
    task automatic step(bit wr, logic [7:0] ofs, logic [31:0] wd, int cls,
                        logic [31:0] a, string tag);
        @(negedge clk);
        cfg_wr_en = wr; cfg_addr = ofs; cfg_wdata = wd;
        mst_class = 2'(cls); req_addr = a;
        #1;
        check(tag);
        @(posedge clk);
        if (wr && ofs == 8'h00) model = int'(wd & 32'h0000_001B);
        #0.5;
        cfg_wr_en = 1'b0;
    endtask

    task automatic probe_all(string phase);
        logic [31:0] pts [10] = '{32'h0000_0000, 32'h0000_FFFF, 32'h0001_0000,
            32'hC000_0000, 32'hFBE0_0000, 32'hFBFF_FFFF, 32'hFC00_0000,
            32'hFD00_0000, 32'hFFFD_1234, 32'hFFFF_FFFC};
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 10; i++)
                step(0, 8'h00, '0, c, pts[i], phase == "" ? req_of(c, pts[i]) : phase);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        probe_all("R1");
        for (int k = 0; k < 16; k++) begin
            logic [31:0] wd;
            wd = {27'(k[3]), 1'b0, 1'b0, 1'b0, 1'b0} << 0;
            wd = 32'(k[0]) | (32'(k[1]) << 1) | (32'(k[2]) << 3) | (32'(k[3]) << 4);
            // R3: reserved bits set alongside
            wd = wd | ((k % 2 == 0) ? 32'hFFFF_FFE4 : 32'h5A5A_0004);
            // R2: write and decode in the same cycle use the old word
            step(1, 8'h00, wd, k % 2, 32'h0000_0100, "R2");
            step(0, 8'h00, '0, 1 - (k % 2), 32'h0000_0200, "R2");
            probe_all("");
            step(0, 8'h00, '0, 0, 32'hFBF0_0000, "R3");
        end
        // R2: writes to other offsets are ignored
        step(1, 8'h04, 32'h0000_0000, 0, 32'h0000_0000, "R2");
        step(1, 8'h80, 32'h0000_0000, 2, 32'hC000_1000, "R2");
        probe_all("R2");
        // R1: reset in mid-run returns to boot ROM / SDRAM defaults
        @(negedge clk) rst_n = 1'b0;
        #1 model = 0;
        @(negedge clk) rst_n = 1'b1;
        probe_all("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        done = 1;
        $finish;
    end
endmodule